// File: doc/BRIEF.md
# Phase-Selectable Half-Rate Clock Generator

This block takes a reference clock and produces four clock outputs at exactly half its rate. All four outputs follow one shared internal toggle. A per-output phase select sets the phase of each output. A high select puts its output in phase with the toggle. A low select gives the opposite phase. The outputs therefore fall into two groups, and each group is the complement of the other. The block suits systems that need several half-rate clocks whose relative phases can be moved at run time.

Every select and the active-low power-down pass through two register stages on the reference clock before they act. Every output is a register on that clock, and no clock is gated by logic. This means a phase change can only hold an output level for one extra reference period. It can never cut a level short.

When all selects are low, the divider stops and every output sits low. When power-down is asserted, the divider stops in the same way and every output sits low. Leaving either state restarts the toggle from a fixed state. The first edge of each output is then a clean rising edge.

Top module: `phase_div2_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` is 0.
- R2: While running (power-down released and at least one select high) with the selects steady, every output inverts on every reference clock edge. Each output therefore runs at half the reference frequency.
- R3: While running with the selects steady, outputs whose `phase_sel` bit is 1 are equal to each other. Outputs whose bit is 0 are equal to the complement of that value.
- R4: When `phase_sel` is 4'b0000, every output is 0 from the third reference edge after the change onward.
- R5: When `pd_n` is 0, every output is 0 from the third reference edge after the assertion onward. The outputs still toggle on the second edge.
- R6: After a restart (leaving all-selects-low, or releasing `pd_n`), on the third edge `clk_out` equals `phase_sel`. On each edge after that, every bit inverts.
- R7: When a select changes while running, the new phase shows on the third edge and not before. The affected output holds its level across that edge, so the level lasts two reference periods. No output level ever lasts less than one reference period.
- R8: Both `phase_sel` and `pd_n` pass through a two-stage synchroniser. That sets the three-edge latency of R4 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| phase_sel | input | 4 | Per-output phase select: 1 = in phase with toggle, 0 = opposite phase |
| clk_out | output | 4 | Half-rate clock outputs |

## Verification
A change on a select or on power-down is captured on the first reference edge and reaches the second synchroniser stage on the second edge. The output register uses it on the third edge. So a new phase, a forced-low state or the first restart pulse appears in the sample taken just after that third edge. The bench drives stimulus on falling edges and samples on falling edges. Directed cases check the sample after the second edge, which must still show the old behaviour, and the samples after the third and later edges, which must show the new one. The random phase waits three edges before checking the toggle and group relations.

// File: rtl/phase_div2_gen.sv
module phase_div2_gen #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [N_OUT-1:0] phase_sel,
  output logic [N_OUT-1:0] clk_out
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [N_OUT-1:0] sel_pipe [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] pd_pipe;
  logic [N_OUT-1:0] sel_q;
  logic pd_q;
  logic run;
  logic tgl;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sel_pipe[s] <= '0;
      pd_pipe <= '0;
    end else begin
      sel_pipe[0] <= phase_sel;
      pd_pipe[0]  <= pd_n;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        sel_pipe[s] <= sel_pipe[s-1];
        pd_pipe[s]  <= pd_pipe[s-1];
      end
    end
  end

  assign sel_q = sel_pipe[LAST];
  assign pd_q  = pd_pipe[LAST];
  assign run   = pd_q && (|sel_q);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)   tgl <= 1'b0;
    else if (run) tgl <= ~tgl;
    else          tgl <= 1'b0;
  end

  // next level: in phase with the toggle's next value, or its complement
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      clk_out <= '0;
    end else begin
      for (int i = 0; i < N_OUT; i++)
        clk_out[i] <= run && (sel_q[i] ? ~tgl : tgl);
    end
  end

endmodule

// File: rtl/phase_div2_gen_chk.sv
module phase_div2_gen_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] sel_q,
  input logic             pd_q,
  input logic             run,
  input logic             tgl,
  input logic [N_OUT-1:0] clk_out
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_reset_low: assert property (@(posedge clk) (!rst_n) |-> (clk_out == '0));

  a_r4_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> (clk_out == '0));

  a_r5_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_q) |=> (clk_out == '0 && !tgl));

  a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(run) && $past(run, 2) && ($past(sel_q) == $past(sel_q, 2)))
      |-> (clk_out == ~$past(clk_out)));

  a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !$past(run) && run) |=> (clk_out == $past(sel_q)));

endmodule

bind phase_div2_gen phase_div2_gen_chk #(.N_OUT(N_OUT)) chk_i (
  .clk(clk_in), .rst_n(rst_n), .sel_q(sel_q), .pd_q(pd_q),
  .run(run), .tgl(tgl), .clk_out(clk_out)
);

// File: tb/phase_div2_gen_tb.sv
`timescale 1ns/1ps
module phase_div2_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic [3:0] sel = 4'b0000;
  logic [3:0] out;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  phase_div2_gen dut_i (.clk_in(clk), .rst_n(rst_n), .pd_n(pd_n), .phase_sel(sel), .clk_out(out));

  function automatic logic [3:0] group_exp(input logic [3:0] s, input logic [3:0] o);
    logic r = 1'b0;
    for (int i = 3; i >= 0; i--) if (s[i]) r = o[i];
    return r ? s : ~s;
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [3:0] a, b, c, prev;
    logic [3:0] rs;
    logic rp;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk("R1 reset", out, 4'b0000);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R4 idle all-low after reset", out, 4'b0000);

    // R6 restart from all-low
    sel = 4'b0101;
    step(); step(); chk("R6 no pulse before third edge", out, 4'b0000);
    step(); chk("R6 first edge equals select", out, 4'b0101);
    step(); chk("R6 R2 inverts", out, 4'b1010);
    step(); chk("R6 R3 groups", out, 4'b0101);

    // R7 phase change on bit 2: 0101 -> 0001
    sel = 4'b0001;
    step(); a = out; step(); b = out; step(); c = out;
    chk("R7 still toggling at second edge", a ^ b, 4'b1111);
    chk("R7 bit2 holds level, others toggle", b ^ c, 4'b1011);
    step(); chk("R7 R3 new grouping", out, group_exp(4'b0001, out));
    chk("R7 R2 toggles after change", out, ~c);

    // R5 power-down while running
    sel = 4'b1111;
    repeat (4) step();
    pd_n = 1'b0;
    step(); a = out; step(); b = out;
    chk("R5 toggles on second edge", b, ~a);
    step(); chk("R5 forced low third edge", out, 4'b0000);
    repeat (3) step();
    chk("R5 stays low", out, 4'b0000);
    sel = 4'b0110;
    repeat (3) step();
    chk("R5 select ignored in power-down", out, 4'b0000);
    pd_n = 1'b1;
    step(); step(); chk("R6 R8 low until third edge", out, 4'b0000);
    step(); chk("R6 pd release first edge", out, 4'b0110);
    step(); chk("R6 pd release inverts", out, 4'b1001);

    // R4 all selects low while running
    sel = 4'b0000;
    step(); step();
    chk("R4 R8 still running at second edge", out, 4'b1001);
    step(); chk("R4 forced low", out, 4'b0000);
    repeat (2) step(); chk("R4 stays low", out, 4'b0000);

    // random mix
    for (int it = 0; it < 60; it++) begin
      rs = 4'($urandom % 16);
      rp = ($urandom % 5) != 0;
      sel = rs; pd_n = rp;
      repeat (3) step();
      prev = out;
      for (int k = 0; k < 4; k++) begin
        if (k > 0) step();
        if (!rp || rs == 4'b0000) chk("R4 R5 random low", out, 4'b0000);
        else begin
          if (k > 0) chk("R2 random toggle", out, ~prev);
          chk("R3 random grouping", out, group_exp(rs, out));
        end
        prev = out;
      end
    end

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", out, 4'b0000);
    summary();
  end
endmodule